// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

The block holds a byte-addressed bank of counter storage (2048 bytes by default) behind a single-beat load/store slave port. Any naturally aligned 8-, 16-, 32- or 64-bit slice of the bank can be read or updated atomically. Software uses it for shared counters that many agents bump at the same time without locks.

A load carries a small signed increment inside its own address. It returns the slice's value from before the update, and the bank keeps the sum. A store adds its data to the slice or overwrites the slice with it. One address bit picks between the two. Each request is decoded, read, modified and written back in a single clock. The response is registered and appears on the next cycle, so consecutive requests never see stale data.

Top module: `fetch_add_bank`

## Requirements
- R1: While `rst_ni` is low, and after its release, every byte of the bank reads as zero and `rsp_valid_o` is low until the first request.
- R2: Every cycle with `req_valid_i` high produces exactly one response, with `rsp_valid_o` high on the following cycle. A cycle without a request produces no response.
- R3: A load returns the slice's previous value, right-justified and sign-extended to 64 bits. The slice is addressed by bits 10:0 of `req_addr_i`. Its width comes from `req_size_i`: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits, 3 for 64 bits. The slice then holds the previous value plus the increment.
- R4: The load increment is the 22-bit two's-complement field at address bits 35:14. It is sign-extended to the access width before the add, so negative increments count down.
- R5: A store with address bit 13 at 0 adds `req_wdata_i` to the slice.
- R6: A store with address bit 13 at 1 replaces the slice with the low bits of `req_wdata_i`.
- R7: Storage is little-endian. A slice occupies the bytes from its address up to address plus width minus one. Every other byte of the bank is left untouched.
- R8: An address that is not a multiple of the access width in bytes gets `rsp_err_o` high and zero data, and leaves the bank unchanged. An aligned access gets `rsp_err_o` low.
- R9: A request issued on the cycle right after another request to the same slice observes that earlier request's result.
- R10: A store response carries zero data.
- R11: Sums wrap modulo 2 to the power of the access width. A carry never spills into neighbouring bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 36 | Byte address (10:0), store mode (13), load increment (35:14) |
| req_size_i | input | 2 | Access width code: 0 byte, 1 half, 2 word, 3 double |
| req_wdata_i | input | 64 | Store operand, right-justified |
| rsp_valid_o | output | 1 | Response present |
| rsp_err_o | output | 1 | Misaligned access |
| rsp_rdata_o | output | 64 | Sign-extended prior slice value for loads, zero otherwise |

## Verification
Every result is due exactly one clock after its request: the storage update and the response register share the same edge. The bench drives each request on a falling edge and checks the response on the next falling edge. It drives the following request at that same instant, so the back-to-back ordering of R9 falls out of every sweep. Storage effects such as untouched lanes and misaligned writes that must be discarded appear one cycle later, through zero-increment loads compared with the bench's byte-array model.

// File: rtl/fab_pkg.sv
package fab_pkg;
  localparam int WORD_W     = 64;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } fab_size_e;

  function automatic logic [WORD_W-1:0] sext_by_size(input logic [WORD_W-1:0] v,
                                                     input fab_size_e s);
    logic [WORD_W-1:0] r;
    case (s)
      SZ_BYTE: r = {{(WORD_W-8){v[7]}},   v[7:0]};
      SZ_HALF: r = {{(WORD_W-16){v[15]}}, v[15:0]};
      SZ_WORD: r = {{(WORD_W-32){v[31]}}, v[31:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_BYTES-1:0] byte_span(input fab_size_e s);
    logic [WORD_BYTES-1:0] m;
    case (s)
      SZ_BYTE: m = WORD_BYTES'(8'h01);
      SZ_HALF: m = WORD_BYTES'(8'h03);
      SZ_WORD: m = WORD_BYTES'(8'h0f);
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic misaligned(input logic [LANE_W-1:0] lane, input fab_size_e s);
    logic r;
    case (s)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = lane[0];
      SZ_WORD: r = |lane[1:0];
      default: r = |lane;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fab_decode.sv
module fab_decode
  import fab_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int OFF_BITS = 11,
  parameter int INC_W    = 22,
  parameter int INC_LSB  = 14,
  parameter int MODE_BIT = 13,
  localparam int IDX_W   = OFF_BITS - LANE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  fab_size_e         size_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              misalign_o,
  output logic              overwrite_o,
  output logic [WORD_W-1:0] inc_o
);
  logic [INC_W-1:0] inc_raw;
  logic             unused_addr;

  assign idx_o       = addr_i[OFF_BITS-1:LANE_W];
  assign lane_o      = addr_i[LANE_W-1:0];
  assign overwrite_o = addr_i[MODE_BIT];
  assign inc_raw     = addr_i[INC_LSB +: INC_W];
  assign inc_o       = {{(WORD_W-INC_W){inc_raw[INC_W-1]}}, inc_raw};
  assign misalign_o  = misaligned(lane_o, size_i);
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/fab_lanes.sv
module fab_lanes
  import fab_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  fab_size_e         size_i,
  input  logic [WORD_W-1:0] new_i,
  output logic [WORD_W-1:0] old_o,
  output logic [WORD_W-1:0] merged_o
);
  logic [WORD_W-1:0]     shifted;
  logic [WORD_W-1:0]     placed;
  logic [WORD_BYTES-1:0] bmask;

  assign shifted = word_i >> {lane_i, 3'b000};
  assign old_o   = sext_by_size(shifted, size_i);
  assign placed  = new_i << {lane_i, 3'b000};
  assign bmask   = byte_span(size_i) << lane_i;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    assign merged_o[8*b +: 8] = bmask[b] ? placed[8*b +: 8] : word_i[8*b +: 8];
  end
endmodule

// File: rtl/fab_alu.sv
module fab_alu
  import fab_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic              overwrite_i,
  output logic [WORD_W-1:0] res_o
);
  // upper bits beyond the slice are dropped by the lane merge, giving the wrap
  assign res_o = overwrite_i ? opnd_i : old_i + opnd_i;
endmodule

// File: rtl/fetch_add_bank.sv
module fetch_add_bank
  import fab_pkg::*;
#(
  parameter int BANK_BYTES = 2048,
  parameter int ADDR_W     = 36,
  parameter int INC_W      = 22,
  parameter int INC_LSB    = 14,
  parameter int MODE_BIT   = 13,
  localparam int OFF_BITS  = $clog2(BANK_BYTES),
  localparam int IDX_W     = OFF_BITS - LANE_W,
  localparam int DEPTH     = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [63:0]       rsp_rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  fab_size_e         size;
  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] lane;
  logic              misalign, mode_ovw;
  logic [WORD_W-1:0] inc_ext, cur_word, old_slice, merged, opnd, result;

  assign size = fab_size_e'(req_size_i);

  fab_decode #(
    .ADDR_W  (ADDR_W),
    .OFF_BITS(OFF_BITS),
    .INC_W   (INC_W),
    .INC_LSB (INC_LSB),
    .MODE_BIT(MODE_BIT)
  ) u_dec (
    .addr_i     (req_addr_i),
    .size_i     (size),
    .idx_o      (idx),
    .lane_o     (lane),
    .misalign_o (misalign),
    .overwrite_o(mode_ovw),
    .inc_o      (inc_ext)
  );

  assign cur_word = mem_q[idx];
  assign opnd     = req_write_i ? req_wdata_i : inc_ext;

  fab_alu u_alu (
    .old_i      (old_slice),
    .opnd_i     (opnd),
    .overwrite_i(req_write_i & mode_ovw),
    .res_o      (result)
  );

  fab_lanes u_lanes (
    .word_i  (cur_word),
    .lane_i  (lane),
    .size_i  (size),
    .new_i   (result),
    .old_o   (old_slice),
    .merged_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (req_valid_i && !misalign) begin
      mem_q[idx] <= merged;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & misalign;
      rsp_rdata_o <= (req_valid_i && !misalign && !req_write_i) ? old_slice : '0;
    end
  end
endmodule

// File: rtl/fetch_add_bank_chk.sv
module fetch_add_bank_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [63:0]       rsp_rdata_o
);
  logic mis;
  always_comb begin
    case (req_size_i)
      2'd0:    mis = 1'b0;
      2'd1:    mis = req_addr_i[0];
      2'd2:    mis = req_addr_i[1:0] != 2'b00;
      default: mis = req_addr_i[2:0] != 3'b000;
    endcase
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !rsp_valid_o && !rsp_err_o && rsp_rdata_o == 64'd0);

  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_err_o);

  assert_misalign_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mis |=> rsp_err_o && rsp_rdata_o == 64'd0);

  assert_aligned_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !mis |=> !rsp_err_o);

  assert_store_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i |=> rsp_rdata_o == 64'd0);

  assert_byte_sext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_size_i == 2'd0
      |=> rsp_rdata_o[63:8] == {56{rsp_rdata_o[7]}});

  assert_half_sext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_size_i == 2'd1 && !mis
      |=> rsp_rdata_o[63:16] == {48{rsp_rdata_o[15]}});
endmodule

bind fetch_add_bank fetch_add_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_size_i (req_size_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/fetch_add_bank_tb_top.sv
module fetch_add_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BANK       = 64;
  localparam int ADDR_W     = 36;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_size_i = '0;
  logic [63:0]       req_wdata_i = '0;
  logic              rsp_valid_o, rsp_err_o;
  logic [63:0]       rsp_rdata_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic [7:0] mdl [BANK];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_add_bank #(.BANK_BYTES(BANK), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o)
  );

  function automatic logic [63:0] sx(input logic [63:0] v, input int sz);
    case (sz)
      0: return {{56{v[7]}}, v[7:0]};
      1: return {{48{v[15]}}, v[15:0]};
      2: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [63:0] mdl_get(input int a, input int sz);
    logic [63:0] v = '0;
    for (int b = 0; b < (1 << sz); b++) v[8*b +: 8] = mdl[a+b];
    return sx(v, sz);
  endfunction

  task automatic mdl_put(input int a, input int sz, input logic [63:0] v);
    for (int b = 0; b < (1 << sz); b++) mdl[a+b] = v[8*b +: 8];
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives at a falling edge, checks at the next one; calls chain back-to-back
  task automatic do_op(input bit wr, input bit ovw, input int a, input int sz,
                       input logic [21:0] inc, input logic [63:0] wd, input string tag);
    bit          mis = (a & ((1 << sz) - 1)) != 0;
    logic [63:0] exp_d, old, opnd, nv;
    string       t = mis ? "R8" : tag;
    exp_d = (wr || mis) ? 64'd0 : mdl_get(a, sz);
    if (!mis) begin
      old  = mdl_get(a, sz);
      opnd = wr ? wd : {{42{inc[21]}}, inc};
      nv   = (wr && ovw) ? opnd : old + opnd;
      mdl_put(a, sz, nv);
    end
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_size_i  = 2'(sz);
    req_wdata_i = wd;
    req_addr_i  = '0;
    req_addr_i[10:0]  = 11'(a);
    req_addr_i[13]    = ovw;
    req_addr_i[35:14] = inc;
    @(negedge clk);
    check(rsp_valid_o === 1'b1 && rsp_err_o === mis && rsp_rdata_o === exp_d,
          t, rsp_rdata_o, exp_d);
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic readback_all(input string tag);
    for (int a = 0; a < BANK; a += 8) do_op(0, 0, a, 3, 22'd0, 64'd0, tag);
    idle();
  endtask

  initial begin
    for (int i = 0; i < BANK; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(rsp_valid_o === 1'b0 && rsp_rdata_o === 64'd0, "R1", rsp_rdata_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rsp_valid_o === 1'b0, "R2", {63'd0, rsp_valid_o}, 64'd0);
    readback_all("R1");

    // every width at every address: loads with varied increments
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < BANK; a++)
        do_op(0, 0, a, sz, 22'((a * 40503 + sz * 7919 + 1) ^ ((a & 1) ? 22'h3fffff : 0)),
              64'd0, (a & 1) ? "R4" : "R3");
    idle();
    check(rsp_valid_o === 1'b0, "R2", {63'd0, rsp_valid_o}, 64'd0);
    readback_all("R7");

    // stores: add then overwrite across widths and addresses
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < BANK; a += 3) begin
        do_op(1, 0, a, sz, 22'd0, {32'hdead_0000 ^ 32'(a), 32'h1357_9bdf * 32'(sz + 1)}, "R5");
        do_op(1, 1, a, sz, 22'd0, {32'(a * 977), 32'hc0ff_ee00 + 32'(sz)}, "R6");
      end
    idle();
    readback_all("R7");

    // wrap at each width, extreme increments
    do_op(1, 1, 8, 0, 22'd0, 64'h7f, "R6");
    do_op(0, 0, 8, 0, 22'd1, 64'd0, "R11");
    do_op(0, 0, 8, 0, 22'd0, 64'd0, "R11");
    do_op(1, 1, 16, 1, 22'd0, 64'hffff, "R6");
    do_op(0, 0, 16, 1, 22'd1, 64'd0, "R11");
    do_op(0, 0, 16, 1, 22'd0, 64'd0, "R11");
    do_op(1, 1, 24, 3, 22'd0, 64'hffff_ffff_ffff_ffff, "R6");
    do_op(0, 0, 24, 3, 22'd1, 64'd0, "R11");
    do_op(0, 0, 24, 3, 22'h200000, 64'd0, "R4");
    do_op(0, 0, 24, 3, 22'h1fffff, 64'd0, "R4");
    // back-to-back chain on one 32-bit slice
    for (int k = 0; k < 6; k++) do_op(0, 0, 36, 2, 22'(k * 1000 - 2500), 64'd0, "R9");
    do_op(1, 0, 36, 2, 22'd0, 64'h0000_0001_ffff_ffff, "R9");
    do_op(0, 0, 36, 2, 22'd0, 64'd0, "R9");
    // misaligned stores must not touch storage
    do_op(1, 1, 41, 3, 22'd0, 64'hffff_ffff_ffff_ffff, "R8");
    do_op(1, 0, 46, 2, 22'd0, 64'h1234, "R8");
    do_op(0, 0, 51, 1, 22'd5, 64'd0, "R8");
    idle();
    readback_all("R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule